// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Constant Operand Option

This block multiplies signed fixed-point numbers. Each operand is a two's-complement integer bus with an implied binary exponent, so the real value of a bus equals its integer code times 2 to the power of its exponent. The block works out every exponent at elaboration from a declared magnitude range and a bus width. The user only states how large a signal may become and how many bits it may use.

A parameter selects one of two variants. In the two-operand variant, the block forms the full-width product of two input buses. In the constant variant, the second operand is a real-valued parameter. Elaboration quantises that parameter into a short bus, 18 bits by default, so that the multiplier stays within the operand size of a single hardware DSP multiplier. In both variants the full product carries the sum of the operand exponents and is then shifted onto the output exponent. By default the output exponent comes from the product of the operand ranges. It can instead be pinned to a caller-supplied value, so the result lands in an output format the caller has already chosen. The aligned result is held in a register.

Top module: `fxmul_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `y_o` becomes zero after that edge.
- R2: `y_o` after a rising edge is computed only from `a_i` and `b_i` sampled at that same edge, a latency of one cycle. Inputs that stay constant keep `y_o` constant.
- R3: For a signal of width W and range R > 0, the exponent is the smallest integer e with (2^(W-1)-1)·2^e ≥ R. This rule applies to `a_i`, `b_i`, the constant and the automatic output format.
- R4: In the two-operand variant, the full product is the exact signed product `a_i`·`b_i`, with width A_W+B_W and exponent equal to the sum of the two operand exponents.
- R5: When OUT_FIXED is 0, the output exponent follows R3 with width OUT_W and range equal to the product of the operand ranges.
- R6: When OUT_FIXED is 1, the output exponent is OUT_EXP_SET. If that lies below the product exponent, the product is shifted left by the difference.
- R7: If the output exponent is above the product exponent, the product is shifted right arithmetically, which rounds toward minus infinity. In every case `y_o` holds the low OUT_W bits of the shifted value, so an out-of-range result wraps.
- R8: In the constant variant (CONST_MODE=1), the constant K_VAL is rounded to the nearest K_W-bit code at elaboration, with its exponent set by R3 from |K_VAL|. The product follows R4 to R7 with that code in place of `b_i`, and `b_i` has no effect on `y_o`.
- R9: In the constant variant, for `a_i` within its declared range, the real value of `y_o` differs from the real product a·K_VAL by at most one output LSB plus |a|·2^(k_exp-1).
- R10: A zero code on `a_i`, or on `b_i` in the two-operand variant, gives `y_o` = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | A_W | First operand, signed code |
| b_i | input | B_W | Second operand, signed code; ignored in constant variant |
| y_o | output | OUT_W | Registered aligned product, signed code |

## Verification
Every result appears exactly one rising edge after its operands are sampled, because the only register on the path is the output register. The bench changes operands on a falling edge and compares `y_o` on the next falling edge. It therefore reads each result half a cycle after the edge that captured it, before any newer operands can arrive. Reset clearing is checked on the falling edge that follows the reset edge. The ignored-operand behaviour of the constant variant is checked by changing only `b_i` and reading `y_o` again one cycle later.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

  // 2^e as a real, for elaboration-time format arithmetic
  function automatic real fx_pow2(input int e);
    real r;
    r = 1.0;
    if (e >= 0) begin
      for (int i = 0; i < e; i++) r = r * 2.0;
    end else begin
      for (int i = 0; i < -e; i++) r = r / 2.0;
    end
    return r;
  endfunction

  // smallest e such that (2^(w-1)-1) * 2^e >= range
  function automatic int fx_exp_for(input real range, input int w);
    real cap;
    int  e;
    cap = fx_pow2(w - 1) - 1.0;
    e   = 0;
    if (range > 0.0) begin
      if (cap >= range) begin
        for (int i = 0; i < 300; i++)
          if (cap * fx_pow2(e - 1) >= range) e = e - 1;
      end else begin
        for (int i = 0; i < 300; i++)
          if (cap * fx_pow2(e) < range) e = e + 1;
      end
    end
    return e;
  endfunction

  // nearest integer code of v at exponent e
  function automatic int fx_quant(input real v, input int e);
    real s;
    s = v / fx_pow2(e);
    if (s >= 0.0) return $rtoi(s + 0.5);
    else          return -$rtoi(-s + 0.5);
  endfunction

  function automatic real fx_abs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

endpackage

// File: rtl/fxmul_const_src.sv
module fxmul_const_src #(
  parameter real K_VAL = 1.0,
  parameter int  K_W   = 18
) (
  output logic signed [K_W-1:0] k_o
);
  import fxmul_pkg::*;

  localparam int K_EXP  = fx_exp_for(fx_abs(K_VAL), K_W);
  localparam int K_CODE = fx_quant(K_VAL, K_EXP);
  localparam logic signed [K_W-1:0] K_BUS = K_W'(K_CODE);

  assign k_o = K_BUS;
endmodule

// File: rtl/fxmul_core.sv
module fxmul_core #(
  parameter int AW = 25,
  parameter int BW = 25,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  assign a_ext = {{BW{a_i[AW-1]}}, a_i};
  assign b_ext = {{AW{b_i[BW-1]}}, b_i};
  assign p_o   = a_ext * b_ext;
endmodule

// File: rtl/fxmul_align.sv
module fxmul_align #(
  parameter int IN_W  = 50,
  parameter int OUT_W = 25,
  parameter int SHIFT = 0
) (
  input  logic signed [IN_W-1:0]  p_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int LSH   = (SHIFT < 0) ? -SHIFT : 0;
  localparam int RSH   = (SHIFT > 0) ? SHIFT : 0;
  localparam int EXT_W = IN_W + OUT_W + LSH;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] moved;
  logic                    unused_hi;

  assign ext = {{(EXT_W-IN_W){p_i[IN_W-1]}}, p_i};

  generate
    if (SHIFT > 0) begin : g_right
      assign moved = ext >>> RSH;
    end else if (SHIFT < 0) begin : g_left
      assign moved = ext <<< LSH;
    end else begin : g_pass
      assign moved = ext;
    end
  endgenerate

  assign y_o       = moved[OUT_W-1:0];
  assign unused_hi = ^moved[EXT_W-1:OUT_W];
endmodule

// File: rtl/fxmul_top.sv
module fxmul_top #(
  parameter int  A_W         = 25,
  parameter real A_RANGE     = 1.0,
  parameter int  B_W         = 25,
  parameter real B_RANGE     = 1.0,
  parameter bit  CONST_MODE  = 1'b0,
  parameter real K_VAL       = 1.0,
  parameter int  K_W         = 18,
  parameter int  OUT_W       = 25,
  parameter bit  OUT_FIXED   = 1'b0,
  parameter int  OUT_EXP_SET = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [B_W-1:0]   b_i,
  output logic signed [OUT_W-1:0] y_o
);
  import fxmul_pkg::*;

  localparam int  M_W      = CONST_MODE ? K_W : B_W;
  localparam real M_RANGE  = CONST_MODE ? fx_abs(K_VAL) : B_RANGE;
  localparam int  A_EXP    = fx_exp_for(A_RANGE, A_W);
  localparam int  M_EXP    = fx_exp_for(M_RANGE, M_W);
  localparam int  P_W      = A_W + M_W;
  localparam int  P_EXP    = A_EXP + M_EXP;
  localparam int  AUTO_EXP = fx_exp_for(A_RANGE * M_RANGE, OUT_W);
  localparam int  OUT_EXP  = OUT_FIXED ? OUT_EXP_SET : AUTO_EXP;
  localparam int  SHIFT    = OUT_EXP - P_EXP;

  logic signed [M_W-1:0]   m_op;
  logic signed [P_W-1:0]   prod;
  logic signed [OUT_W-1:0] aligned;

  generate
    if (CONST_MODE) begin : g_const
      logic unused_b;
      assign unused_b = ^b_i;
      fxmul_const_src #(.K_VAL(K_VAL), .K_W(K_W)) u_ksrc (.k_o(m_op));
    end else begin : g_var
      assign m_op = b_i;
    end
  endgenerate

  fxmul_core #(.AW(A_W), .BW(M_W)) u_core (
    .a_i(a_i),
    .b_i(m_op),
    .p_o(prod)
  );

  fxmul_align #(.IN_W(P_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_align (
    .p_i(prod),
    .y_o(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= aligned;
  end
endmodule

// File: rtl/fxmul_chk.sv
module fxmul_chk #(
  parameter bit CONST_MODE = 1'b0,
  parameter int A_W        = 25,
  parameter int B_W        = 25,
  parameter int OUT_W      = 25
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [A_W-1:0]   a_i,
  input logic signed [B_W-1:0]   b_i,
  input logic signed [OUT_W-1:0] y_o
);
  // high when the previous edge was not a reset edge
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (y_o == '0));

  a_r10_zero_a: assert property (@(posedge clk) disable iff (rst)
    (a_i == '0) |=> (y_o == '0));

  generate
    if (CONST_MODE) begin : g_kchk
      // R8: b_i has no influence, so stable a_i keeps y_o stable
      a_r8_b_ignored: assert property (@(posedge clk) disable iff (rst)
        (live && $stable(a_i)) |=> $stable(y_o));
    end else begin : g_vchk
      a_r10_zero_b: assert property (@(posedge clk) disable iff (rst)
        (b_i == '0) |=> (y_o == '0));
      a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (live && $stable(a_i) && $stable(b_i)) |=> $stable(y_o));
    end
  endgenerate
endmodule

bind fxmul_top fxmul_chk #(
  .CONST_MODE(CONST_MODE),
  .A_W(A_W),
  .B_W(B_W),
  .OUT_W(OUT_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .a_i(a_i),
  .b_i(b_i),
  .y_o(y_o)
);

// File: tb/fxmul_top_tb_top.sv
module fxmul_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // variable-variable instances: A 6 bits range 4 (exp -2), B 5 bits range 2 (exp -2)
  logic signed [5:0]  a_v;
  logic signed [4:0]  b_v;
  logic signed [7:0]  y_auto;   // auto: range 8, 8 bits -> exp -3, shift right 1
  logic signed [9:0]  y_fix;    // fixed exp -6, shift left 2
  // constant instance: A 8 bits range 4 (exp -4), K=1.3 at 18 bits (exp -16, code 85197)
  logic signed [7:0]  a_k;
  logic signed [4:0]  b_k;
  logic signed [11:0] y_k;      // auto: range 5.2, 12 bits -> exp -8, shift right 12

  fxmul_top #(.A_W(6), .A_RANGE(4.0), .B_W(5), .B_RANGE(2.0), .OUT_W(8)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_v), .b_i(b_v), .y_o(y_auto));

  fxmul_top #(.A_W(6), .A_RANGE(4.0), .B_W(5), .B_RANGE(2.0), .OUT_W(10),
              .OUT_FIXED(1'b1), .OUT_EXP_SET(-6)) dut_x_i (
    .clk(clk), .rst(rst), .a_i(a_v), .b_i(b_v), .y_o(y_fix));

  fxmul_top #(.A_W(8), .A_RANGE(4.0), .B_W(5), .CONST_MODE(1'b1), .K_VAL(1.3),
              .K_W(18), .OUT_W(12)) dut_k_i (
    .clk(clk), .rst(rst), .a_i(a_k), .b_i(b_k), .y_o(y_k));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check_int(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int sx8(input int v);
    logic signed [7:0] t;
    t = v[7:0];
    return int'(t);
  endfunction
  function automatic int sx10(input int v);
    logic signed [9:0] t;
    t = v[9:0];
    return int'(t);
  endfunction
  function automatic int sx12(input longint v);
    logic signed [11:0] t;
    t = v[11:0];
    return int'(t);
  endfunction

  initial begin
    a_v = '0; b_v = '0; a_k = '0; b_k = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_int("R1 reset auto", int'(y_auto), 0);
    check_int("R1 reset fixed", int'(y_fix), 0);
    check_int("R1 reset const", int'(y_k), 0);
    rst = 1'b0;

    // R2/R3/R4/R5/R7/R10 auto format, R6 fixed format: exhaustive sweep
    for (int ia = -32; ia < 32; ia++) begin
      for (int ib = -16; ib < 16; ib++) begin
        int p;
        a_v = 6'(ia);
        b_v = 5'(ib);
        @(negedge clk);
        p = ia * ib;
        check_int("R4/R5/R7/R10 auto", int'(y_auto), sx8(p >>> 1));
        check_int("R4/R6 fixed", int'(y_fix), sx10(p <<< 2));
      end
    end

    // R8/R9 constant: exact code check plus real reference, b_k varied
    for (int ia = -128; ia < 128; ia++) begin
      longint p;
      a_k = 8'(ia);
      b_k = 5'(ia * 7 + 3);
      @(negedge clk);
      p = longint'(ia) * 64'sd85197;
      check_int("R8 const code", int'(y_k), sx12(p >>> 12));
      if (ia >= -64 && ia <= 64) begin
        real ref_v, got_v, tol;
        ref_v = real'(ia) * 0.0625 * 1.3;
        got_v = real'(y_k) / 256.0;
        tol   = 1.0 / 256.0 + ((ia < 0) ? -real'(ia) : real'(ia)) * 0.0625 / 131072.0 + 1.0e-9;
        n_chk++;
        if (((got_v - ref_v) > tol) || ((ref_v - got_v) > tol)) begin
          n_fail++;
          $display("FAIL R9 accuracy a=%0d: got %f expected %f", ia, got_v, ref_v);
        end
      end
    end

    // R8: only b_i changes, y_o must stay put
    a_k = 8'sd37; b_k = 5'sd5;
    @(negedge clk);
    b_k = -5'sd9;
    @(negedge clk);
    check_int("R8 b ignored", int'(y_k), sx12((longint'(37) * 64'sd85197) >>> 12));

    // R2: hold inputs, output stays the same
    a_v = -6'sd7; b_v = 5'sd11;
    repeat (3) @(negedge clk);
    check_int("R2 hold auto", int'(y_auto), sx8((-77) >>> 1));

    // R1: reset in mid-operation
    rst = 1'b1;
    @(negedge clk);
    check_int("R1 mid reset auto", int'(y_auto), 0);
    check_int("R1 mid reset fixed", int'(y_fix), 0);
    check_int("R1 mid reset const", int'(y_k), 0);
    rst = 1'b0;
    @(negedge clk);
    check_int("R2 after reset", int'(y_auto), sx8((-77) >>> 1));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule